// File: doc/BRIEF.md
# Compressed Table-Jump Unit

This block runs the two 16-bit table-jump instructions of a RISC-V core. One instruction encoding serves both of them. An 8-bit index in the instruction selects an entry in a jump table held in memory. A vector CSR points to that table. The block reads one XLEN-wide entry through a simple request/response port. It then reports one of three outcomes: a redirect to the fetched target, an exception with its cause and address, or an illegal-instruction flag. When the index is 32 or more, the instruction also links: it hands the core a return address to write into x1.

The block owns the vector CSR and answers CSR accesses at address 0x017. Table jumps and compressed double-precision loads and stores share encodings, so the unit turns itself off while the double-precision feature is on. While it is off, the CSR address counts as undefined. The control path is a three-state machine:

- IDLE waits for an instruction.
- FETCH holds the memory request until a response arrives.
- DONE presents the outcome for one cycle.

The transitions are:

- accept-to-fetch: IDLE to FETCH, when the mode is zero and the entry is aligned.
- accept-to-done: IDLE to DONE, for the illegal or misaligned outcomes.
- response: FETCH to DONE.
- retire: DONE to IDLE.

Top module: `tbljmp_unit`

## Requirements
- R1: A 16-bit word is accepted only when bits [15:13]=101, [12:10]=000 and [1:0]=10, with `ins_valid` high and `ins_ready` high. Any other word produces no memory request and no outcome. The index is bits [9:2].
- R2: An index below 32 is a plain jump: `res_rd_we` stays 0. An index of 32 or more links: `res_rd_we`=1 and `res_rd_data` = pc+2, in the same cycle as the redirect.
- R3: At CSR address 0x017, a write stores bits [XLEN-1:6] of the written value and clears bits [5:0]. `csr_rdata` returns the whole register while `csr_defined` is 1. Any other address gives `csr_defined`=0 and `csr_rdata`=0.
- R4: After reset the vector register equals parameter RST_VEC, `ins_ready` is 1, and no request or outcome is active.
- R5: `mem_addr` = ({vector[XLEN-1:6], 6'b0}) + index × XLEN/8. The stride is 4 bytes for XLEN=32 and 8 bytes for XLEN=64.
- R6: If vector bits [5:0] are non-zero, the instruction goes to DONE with `res_illegal`=1 and no memory request is made.
- R7: On a response without error, `res_redirect`=1 and `res_npc` equals the response data with bit 0 cleared.
- R8: On a response with `mem_rerr`=1, the outcome is `res_exc`=1 with `res_exc_cause`=2 (fault) and `res_exc_addr` = entry address. There is no redirect and no register write. Cause 1 marks a misaligned entry address.
- R9: The unit is enabled when `cfg_tj_support`=1 and `cfg_cdls_on`=0. While it is disabled, matching words are not accepted, CSR address 0x017 is undefined, and writes to it are dropped.
- R10: `ins_ready` is 0 from acceptance through the DONE cycle. In DONE exactly one of `res_redirect`, `res_exc` and `res_illegal` is 1, for one cycle only.
- R11: A CSR write in the cycle an instruction is accepted does not change that instruction's entry address. A write during FETCH does not change `mem_addr`. A later instruction uses the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tj_support | input | 1 | Table jump supported |
| cfg_cdls_on | input | 1 | Compressed double load/store enabled |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Unit can accept (IDLE) |
| ins_bits | input | 16 | Compressed instruction word |
| ins_pc | input | XLEN | Address of the instruction |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_defined | output | 1 | Address names the vector CSR and unit enabled |
| csr_rdata | output | XLEN | CSR read data |
| mem_req | output | 1 | Table fetch request, held until response |
| mem_addr | output | XLEN | Table entry address |
| mem_rvalid | input | 1 | Response valid |
| mem_rdata | input | XLEN | Fetched table entry |
| mem_rerr | input | 1 | Fetch failed (fault) |
| res_redirect | output | 1 | Jump to res_npc |
| res_npc | output | XLEN | New PC |
| res_rd_we | output | 1 | Write res_rd_data to x1 |
| res_rd_data | output | XLEN | Return address |
| res_exc | output | 1 | Exception raised |
| res_exc_cause | output | 2 | 1 misaligned, 2 fault |
| res_exc_addr | output | XLEN | Faulting entry address |
| res_illegal | output | 1 | Illegal instruction |

## Verification
Two things can land in the same cycle: a CSR write to the vector register and the acceptance of a table jump. The bench drives both on the same clock edge and expects the entry address to use the previous base. The bench then writes the CSR again while the fetch is in flight. It checks that `mem_addr` holds its value, and that the instruction after that one picks up the latest base.

// File: rtl/tbljmp_pkg.sv
package tbljmp_pkg;

    localparam logic [11:0] VEC_CSR_ADDR = 12'h017;
    localparam int          MODE_W       = 6;
    localparam int          INDEX_W      = 8;
    localparam int          LINK_MIN     = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } tj_state_e;

    typedef enum logic [1:0] {
        EXC_NONE     = 2'd0,
        EXC_MISALIGN = 2'd1,
        EXC_FAULT    = 2'd2
    } tj_exc_e;

    typedef enum logic [1:0] {
        OUT_JUMP  = 2'd0,
        OUT_TRAP  = 2'd1,
        OUT_ILL   = 2'd2
    } tj_out_e;

    typedef struct packed {
        logic               hit;
        logic               link;
        logic [INDEX_W-1:0] index;
    } tj_dec_t;

endpackage

// File: rtl/tbljmp_decode.sv
module tbljmp_decode
    import tbljmp_pkg::*;
(
    input  logic        enable,
    input  logic [15:0] insn,
    output tj_dec_t     dec
);
    logic pattern_ok;

    always_comb begin
        pattern_ok = (insn[15:13] == 3'b101) &&
                     (insn[12:10] == 3'b000) &&
                     (insn[1:0]   == 2'b10);
        dec.hit    = enable && pattern_ok;
        dec.index  = insn[2 +: INDEX_W];
        dec.link   = (insn[2 +: INDEX_W] >= INDEX_W'(LINK_MIN));
    end
endmodule

// File: rtl/tbljmp_vec_csr.sv
module tbljmp_vec_csr
    import tbljmp_pkg::*;
#(
    parameter int              XLEN    = 32,
    parameter logic [XLEN-1:0] RST_VEC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            we,
    input  logic [11:0]     addr,
    input  logic [XLEN-1:0] wdata,
    output logic            defined,
    output logic [XLEN-1:0] rdata,
    output logic [XLEN-1:0] vec,
    output logic            mode_ok
);
    logic [XLEN-1:0] vec_q;

    always_comb begin
        defined = enable && (addr == VEC_CSR_ADDR);
        rdata   = defined ? vec_q : '0;
        vec     = vec_q;
        mode_ok = (vec_q[MODE_W-1:0] == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= RST_VEC;
        end else if (we && defined) begin
            vec_q <= {wdata[XLEN-1:MODE_W], {MODE_W{1'b0}}};
        end
    end
endmodule

// File: rtl/tbljmp_addr_gen.sv
module tbljmp_addr_gen
    import tbljmp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]    vec,
    input  logic [INDEX_W-1:0] index,
    output logic [XLEN-1:0]    entry_addr,
    output logic               misal
);
    localparam int BYTES = XLEN / 8;
    localparam int LG    = $clog2(BYTES);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    always_comb begin
        base       = {vec[XLEN-1:MODE_W], {MODE_W{1'b0}}};
        offset     = XLEN'(index) << LG;
        entry_addr = base + offset;
        misal      = |entry_addr[LG-1:0];
    end
endmodule

// File: rtl/tbljmp_ctrl.sv
module tbljmp_ctrl
    import tbljmp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            mode_ok,
    input  logic            misal,
    input  logic [XLEN-1:0] entry_addr,
    input  logic [XLEN-1:0] pc,
    input  logic            link,
    input  logic            mem_rvalid,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_rerr,
    output logic            idle,
    output logic            mem_req,
    output logic [XLEN-1:0] mem_addr,
    output logic            res_redirect,
    output logic [XLEN-1:0] res_npc,
    output logic            res_rd_we,
    output logic [XLEN-1:0] res_rd_data,
    output logic            res_exc,
    output logic [1:0]      res_exc_cause,
    output logic [XLEN-1:0] res_exc_addr,
    output logic            res_illegal
);
    tj_state_e       state_q, state_d;
    tj_out_e         kind_q;
    tj_exc_e         cause_q;
    logic [XLEN-1:0] addr_q;
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] tgt_q;
    logic            link_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (mode_ok && !misal) ? ST_FETCH : ST_DONE;
                end
            end
            ST_FETCH: begin
                if (mem_rvalid) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // captured operands and outcome
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= OUT_JUMP;
            cause_q <= EXC_NONE;
            addr_q  <= '0;
            pc_q    <= '0;
            tgt_q   <= '0;
            link_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                addr_q <= entry_addr;
                pc_q   <= pc;
                link_q <= link;
                if (!mode_ok) begin
                    kind_q <= OUT_ILL;
                end else if (misal) begin
                    kind_q  <= OUT_TRAP;
                    cause_q <= EXC_MISALIGN;
                end
            end
            if (state_q == ST_FETCH && mem_rvalid) begin
                if (mem_rerr) begin
                    kind_q  <= OUT_TRAP;
                    cause_q <= EXC_FAULT;
                end else begin
                    kind_q <= OUT_JUMP;
                    tgt_q  <= {mem_rdata[XLEN-1:1], 1'b0};
                end
            end
        end
    end

    // outputs
    always_comb begin
        idle          = 1'b0;
        mem_req       = 1'b0;
        mem_addr      = '0;
        res_redirect  = 1'b0;
        res_npc       = '0;
        res_rd_we     = 1'b0;
        res_rd_data   = '0;
        res_exc       = 1'b0;
        res_exc_cause = EXC_NONE;
        res_exc_addr  = '0;
        res_illegal   = 1'b0;
        unique case (state_q)
            ST_IDLE:  idle = 1'b1;
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = addr_q;
            end
            ST_DONE: begin
                unique case (kind_q)
                    OUT_JUMP: begin
                        res_redirect = 1'b1;
                        res_npc      = tgt_q;
                        res_rd_we    = link_q;
                        res_rd_data  = link_q ? (pc_q + XLEN'(2)) : '0;
                    end
                    OUT_TRAP: begin
                        res_exc       = 1'b1;
                        res_exc_cause = cause_q;
                        res_exc_addr  = addr_q;
                    end
                    OUT_ILL:  res_illegal = 1'b1;
                    default:  res_illegal = 1'b1;
                endcase
            end
            default: idle = 1'b0;
        endcase
    end
endmodule

// File: rtl/tbljmp_unit.sv
module tbljmp_unit
    import tbljmp_pkg::*;
#(
    parameter int              XLEN    = 32,
    parameter logic [XLEN-1:0] RST_VEC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_tj_support,
    input  logic            cfg_cdls_on,
    input  logic            ins_valid,
    output logic            ins_ready,
    input  logic [15:0]     ins_bits,
    input  logic [XLEN-1:0] ins_pc,
    input  logic            csr_we,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic            csr_defined,
    output logic [XLEN-1:0] csr_rdata,
    output logic            mem_req,
    output logic [XLEN-1:0] mem_addr,
    input  logic            mem_rvalid,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_rerr,
    output logic            res_redirect,
    output logic [XLEN-1:0] res_npc,
    output logic            res_rd_we,
    output logic [XLEN-1:0] res_rd_data,
    output logic            res_exc,
    output logic [1:0]      res_exc_cause,
    output logic [XLEN-1:0] res_exc_addr,
    output logic            res_illegal
);
    logic            unit_on;
    tj_dec_t         dec;
    logic [XLEN-1:0] vec_q;
    logic            mode_ok;
    logic [XLEN-1:0] entry_addr;
    logic            misal;
    logic            idle;
    logic            start;

    assign unit_on   = cfg_tj_support && !cfg_cdls_on;
    assign ins_ready = idle;
    assign start     = ins_valid && idle && dec.hit;

    tbljmp_decode u_dec (
        .enable (unit_on),
        .insn   (ins_bits),
        .dec    (dec)
    );

    tbljmp_vec_csr #(.XLEN(XLEN), .RST_VEC(RST_VEC)) u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (unit_on),
        .we      (csr_we),
        .addr    (csr_addr),
        .wdata   (csr_wdata),
        .defined (csr_defined),
        .rdata   (csr_rdata),
        .vec     (vec_q),
        .mode_ok (mode_ok)
    );

    tbljmp_addr_gen #(.XLEN(XLEN)) u_agen (
        .vec        (vec_q),
        .index      (dec.index),
        .entry_addr (entry_addr),
        .misal      (misal)
    );

    tbljmp_ctrl #(.XLEN(XLEN)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .mode_ok       (mode_ok),
        .misal         (misal),
        .entry_addr    (entry_addr),
        .pc            (ins_pc),
        .link          (dec.link),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .mem_rerr      (mem_rerr),
        .idle          (idle),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .res_redirect  (res_redirect),
        .res_npc       (res_npc),
        .res_rd_we     (res_rd_we),
        .res_rd_data   (res_rd_data),
        .res_exc       (res_exc),
        .res_exc_cause (res_exc_cause),
        .res_exc_addr  (res_exc_addr),
        .res_illegal   (res_illegal)
    );
endmodule

// File: rtl/tbljmp_unit_chk.sv
module tbljmp_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_tj_support,
    input logic            cfg_cdls_on,
    input logic            ins_valid,
    input logic            ins_ready,
    input logic            csr_we,
    input logic            csr_defined,
    input logic [XLEN-1:0] vec,
    input logic            mem_req,
    input logic [XLEN-1:0] mem_addr,
    input logic            mem_rvalid,
    input logic            res_redirect,
    input logic [XLEN-1:0] res_npc,
    input logic            res_rd_we,
    input logic            res_exc,
    input logic            res_illegal
);
    logic any_out;
    assign any_out = res_redirect || res_exc || res_illegal;

    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_redirect, res_exc, res_illegal}));

    assert_ready_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        any_out |-> !ins_ready);

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        any_out |=> !any_out && ins_ready);

    assert_no_fetch_illegal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_illegal |-> !mem_req);

    assert_even_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_redirect |-> !res_npc[0]);

    assert_link_with_jump_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_rd_we |-> res_redirect);

    assert_addr_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    assert_mode_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_defined) |=> (vec[5:0] == 6'd0));

    assert_off_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((!cfg_tj_support || cfg_cdls_on) && ins_valid && ins_ready)
        |=> (!mem_req && !any_out));
endmodule

bind tbljmp_unit tbljmp_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_tj_support (cfg_tj_support),
    .cfg_cdls_on    (cfg_cdls_on),
    .ins_valid      (ins_valid),
    .ins_ready      (ins_ready),
    .csr_we         (csr_we),
    .csr_defined    (csr_defined),
    .vec            (vec_q),
    .mem_req        (mem_req),
    .mem_addr       (mem_addr),
    .mem_rvalid     (mem_rvalid),
    .res_redirect   (res_redirect),
    .res_npc        (res_npc),
    .res_rd_we      (res_rd_we),
    .res_exc        (res_exc),
    .res_illegal    (res_illegal)
);

// File: tb/tbljmp_unit_test.sv
`timescale 1ns/1ps
module tbljmp_unit_test;
    localparam logic [63:0] W_RST = 64'h5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_tj_support = 1'b1;
    logic        cfg_cdls_on = 1'b0;
    logic        ins_valid = 1'b0;
    logic        ins_ready;
    logic [15:0] ins_bits = '0;
    logic [31:0] ins_pc = '0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic        csr_defined;
    logic [31:0] csr_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_rerr = 1'b0;
    logic        res_redirect;
    logic [31:0] res_npc;
    logic        res_rd_we;
    logic [31:0] res_rd_data;
    logic        res_exc;
    logic [1:0]  res_exc_cause;
    logic [31:0] res_exc_addr;
    logic        res_illegal;

    // 64-bit instance with a non-zero reset mode
    logic        w_ins_valid = 1'b0;
    logic        w_ins_ready;
    logic [15:0] w_ins_bits = '0;
    logic [63:0] w_ins_pc = '0;
    logic        w_csr_we = 1'b0;
    logic [63:0] w_csr_wdata = '0;
    logic        w_csr_defined;
    logic [63:0] w_csr_rdata;
    logic        w_mem_req;
    logic [63:0] w_mem_addr;
    logic        w_mem_rvalid = 1'b0;
    logic [63:0] w_mem_rdata = '0;
    logic        w_redirect;
    logic [63:0] w_npc;
    logic        w_rd_we;
    logic [63:0] w_rd_data;
    logic        w_exc;
    logic [1:0]  w_exc_cause;
    logic [63:0] w_exc_addr;
    logic        w_illegal;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] base_m = '0;

    always #4 clk = ~clk;

    tbljmp_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_tj_support(cfg_tj_support), .cfg_cdls_on(cfg_cdls_on),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_bits(ins_bits), .ins_pc(ins_pc),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_defined(csr_defined), .csr_rdata(csr_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
        .res_redirect(res_redirect), .res_npc(res_npc), .res_rd_we(res_rd_we),
        .res_rd_data(res_rd_data), .res_exc(res_exc), .res_exc_cause(res_exc_cause),
        .res_exc_addr(res_exc_addr), .res_illegal(res_illegal)
    );

    tbljmp_unit #(.XLEN(64), .RST_VEC(W_RST)) uut_w (
        .clk(clk), .rst_n(rst_n), .cfg_tj_support(1'b1), .cfg_cdls_on(1'b0),
        .ins_valid(w_ins_valid), .ins_ready(w_ins_ready), .ins_bits(w_ins_bits), .ins_pc(w_ins_pc),
        .csr_we(w_csr_we), .csr_addr(12'h017), .csr_wdata(w_csr_wdata),
        .csr_defined(w_csr_defined), .csr_rdata(w_csr_rdata),
        .mem_req(w_mem_req), .mem_addr(w_mem_addr), .mem_rvalid(w_mem_rvalid),
        .mem_rdata(w_mem_rdata), .mem_rerr(1'b0),
        .res_redirect(w_redirect), .res_npc(w_npc), .res_rd_we(w_rd_we),
        .res_rd_data(w_rd_data), .res_exc(w_exc), .res_exc_cause(w_exc_cause),
        .res_exc_addr(w_exc_addr), .res_illegal(w_illegal)
    );

    function automatic logic [15:0] enc(input logic [7:0] idx);
        return {3'b101, 3'b000, idx, 2'b10};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
        if (cfg_tj_support && !cfg_cdls_on && a == 12'h017) base_m = d & ~32'h3F;
    endtask

    // full jump with a response after 'dly' cycles
    task automatic t_jump(input logic [7:0] idx, input logic [31:0] pc, input int dly,
                          input logic [31:0] data, input logic err);
        logic [31:0] ea;
        logic        lnk;
        ea  = base_m + {22'd0, idx, 2'b00};
        lnk = (idx >= 8'd32);
        ins_valid = 1'b1; ins_bits = enc(idx); ins_pc = pc;
        @(negedge clk);
        ins_valid = 1'b0;
        check("R5 entry address", mem_addr, ea);
        check("R10 ready low in fetch", ins_ready, 0);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            check("R11 request held", {mem_req, mem_addr}, {1'b1, ea});
        end
        mem_rvalid = 1'b1; mem_rdata = data; mem_rerr = err;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rerr = 1'b0;
        check("R10 ready low in done", ins_ready, 0);
        if (err) begin
            check("R8 fault outcome", {res_exc, res_exc_cause, res_redirect, res_rd_we}, {1'b1, 2'd2, 1'b0, 1'b0});
            check("R8 fault address", res_exc_addr, ea);
        end else begin
            check("R7 redirect", {res_redirect, res_exc, res_illegal}, 3'b100);
            check("R7 target bit0 cleared", res_npc, data & ~32'h1);
            check("R2 link flag", res_rd_we, lnk);
            if (lnk) check("R2 return address", res_rd_data, pc + 32'd2);
        end
        @(negedge clk);
        check("R10 single cycle outcome", {res_redirect, res_exc, res_illegal, ins_ready}, 4'b0001);
    endtask

    task automatic t_ignored(input logic [15:0] w, input string req);
        ins_valid = 1'b1; ins_bits = w;
        @(negedge clk);
        ins_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(req, {mem_req, res_redirect, res_exc, res_illegal, ins_ready}, 5'b00001);
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        check("R4 ready after reset", ins_ready, 1);
        check("R4 idle outputs", {mem_req, res_redirect, res_exc, res_illegal}, 4'b0000);
        csr_addr = 12'h017;
        #1;
        check("R4 reset vector", csr_rdata, 32'h0);
    endtask

    task automatic t_csr;
        csr_write(12'h017, 32'h0000_1ABC);
        check("R3 write clears mode", csr_rdata, 32'h0000_1A80);
        check("R3 defined", csr_defined, 1);
        csr_addr = 12'h018;
        #1;
        check("R3 other address", {csr_defined, csr_rdata}, 33'h0);
        csr_write(12'h018, 32'hFFFF_FFFF);
        csr_addr = 12'h017;
        #1;
        check("R3 other address write dropped", csr_rdata, 32'h0000_1A80);
    endtask

    task automatic t_disabled;
        cfg_cdls_on = 1'b1;
        #1;
        check("R9 CSR undefined", {csr_defined, csr_rdata}, 33'h0);
        t_ignored(enc(8'd3), "R9 no accept while off");
        csr_write(12'h017, 32'h0000_2000);
        cfg_cdls_on = 1'b0;
        cfg_tj_support = 1'b0;
        t_ignored(enc(8'd40), "R9 no accept unsupported");
        cfg_tj_support = 1'b1;
        csr_addr = 12'h017;
        #1;
        check("R9 write dropped", csr_rdata, 32'h0000_1A80);
    endtask

    task automatic t_collide;
        logic [31:0] old_base;
        old_base = base_m;
        csr_we = 1'b1; csr_addr = 12'h017; csr_wdata = 32'h0000_3000;
        ins_valid = 1'b1; ins_bits = enc(8'd1); ins_pc = 32'h200;
        @(negedge clk);
        csr_we = 1'b0; ins_valid = 1'b0;
        check("R11 accept uses old base", mem_addr, old_base + 32'd4);
        check("R11 write taken", csr_rdata, 32'h0000_3000);
        csr_wdata = 32'h0000_5000; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
        check("R11 addr stable after write", mem_addr, old_base + 32'd4);
        mem_rvalid = 1'b1; mem_rdata = 32'h0000_0801;
        @(negedge clk);
        mem_rvalid = 1'b0;
        check("R7 collide redirect", {res_redirect, res_npc}, {1'b1, 32'h0000_0800});
        @(negedge clk);
        base_m = 32'h0000_5000;
        t_jump(8'd1, 32'h300, 0, 32'h0000_0900, 1'b0);
    endtask

    task automatic t_wide;
        w_ins_valid = 1'b1; w_ins_bits = enc(8'd3); w_ins_pc = 64'h40;
        @(negedge clk);
        w_ins_valid = 1'b0;
        check("R6 illegal on mode", {w_illegal, w_mem_req, w_redirect, w_exc}, 4'b1000);
        @(negedge clk);
        check("R6 back to idle", {w_ins_ready, w_mem_req}, 2'b10);
        w_csr_we = 1'b1; w_csr_wdata = 64'h8000_0000_0000_0047;
        @(negedge clk);
        w_csr_we = 1'b0;
        check("R3 64-bit write", w_csr_rdata, 64'h8000_0000_0000_0040);
        w_ins_valid = 1'b1; w_ins_bits = enc(8'd3);
        @(negedge clk);
        w_ins_valid = 1'b0;
        check("R5 stride 8", {w_mem_req, w_mem_addr}, {1'b1, 64'h8000_0000_0000_0058});
        w_mem_rvalid = 1'b1; w_mem_rdata = 64'h1235;
        @(negedge clk);
        w_mem_rvalid = 1'b0;
        check("R7 64-bit target", {w_redirect, w_npc, w_rd_we}, {1'b1, 64'h1234, 1'b0});
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_csr();
        t_jump(8'd5,   32'h0000_0100, 0, 32'h4001_2345, 1'b0);   // R2 plain jump
        t_jump(8'd31,  32'h0000_0104, 2, 32'h0000_0AA0, 1'b0);   // R2 last plain index
        t_jump(8'd32,  32'h0000_0108, 1, 32'h0000_0BB1, 1'b0);   // R2 first linking index
        t_jump(8'd255, 32'h0000_0FFE, 3, 32'h1234_5679, 1'b0);   // R5 top index
        t_jump(8'd7,   32'h0000_0110, 1, 32'h0,         1'b1);   // R8 fault
        t_ignored(16'hA402, "R1 bit10 set ignored");
        t_ignored(16'hA001, "R1 low bits ignored");
        t_ignored(16'h8002, "R1 top bits ignored");
        t_disabled();
        t_collide();
        t_wide();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule